// File: doc/BRIEF.md
# Asynchronous Bus Read Master

This block runs single read transfers as the master of an external bus whose cycles end on a handshake from the addressed device rather than after a fixed count. A request carries an address, a 3-bit address-space code, a 2-bit size code and a flag marking the first external access of an operand. The master then steps through six half-bus-clock phases, S0 to S5, and drives the strobes, the direction line, the data-buffer enable and the size lines in a fixed order. It stretches the cycle with wait states until the device acknowledges.

The block runs on one clock at twice the bus rate, so each phase lasts exactly one clock. The two-bit acknowledge arrives asynchronously and passes through a two-flop synchronizer. The synchronized value is examined at the end of S2. If neither bit is set, the master inserts wait states in pairs of phases, one full bus clock each, and examines the acknowledge again at the end of every pair. After acknowledge it captures the whole 32-bit data bus at the end of S4, drops its strobes after S5 and pulses a one-cycle completion with the captured word.

Top module: `busRdMaster`

## Requirements
- R1: After reset, cycStart, opStart, addrStb, dataStb, bufEn and done are low, and reqReady is high.
- R2: When reqValid is high while reqReady is high, the following clock cycle is S0. In S0, cycStart is high, busAddr, busFc and busSize show the request, busRdWr is high (1 means read), and bufEn, addrStb and dataStb are low.
- R3: opStart is high in S0 only when the request's reqFirst bit was 1. It is low in every other cycle.
- R4: In S1, the cycle after S0, cycStart and opStart are low, addrStb and dataStb are high, and bufEn is still low.
- R5: From S2 through S5, including any wait states, addrStb, dataStb and bufEn are all high.
- R6: busAck is active-high. Either bit set counts as acknowledge, and it reaches the decision logic two clocks after it is sampled. If it is seen during S2, S3 follows directly, and done rises 6 cycles after S0.
- R7: If no acknowledge is seen during S2, wait states are inserted in pairs of two cycles, and the acknowledge is examined again only in the second cycle of each pair. An acknowledge first driven k cycles after the S0 cycle yields ceil(k/2) pairs, and done rises 6 + 2*pairs cycles after S0.
- R8: busData is captured at the clock edge that ends S4. done is high for exactly one cycle, the cycle after S5, with rdData equal to that captured word. Changes on busData during S5 do not affect rdData.
- R9: After S5, all strobes and bufEn are low and reqReady is high. A reqValid pulse during a transfer starts no further cycle. An acknowledge while idle produces no strobe and no done.
- R10: busAddr, busFc and busSize remain constant from S0 to the end of S5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate, one phase per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request |
| reqAddr | input | 32 | Request address |
| reqFc | input | 3 | Request address-space code |
| reqSize | input | 2 | Request size code (00 = 4 bytes, 01..11 = 1..3 bytes) |
| reqFirst | input | 1 | First external access of an operand |
| reqReady | output | 1 | Idle, a request will be accepted |
| busAddr | output | 32 | Bus address |
| busFc | output | 3 | Bus address-space code |
| busSize | output | 2 | Bus size lines |
| busRdWr | output | 1 | Direction, 1 = read |
| cycStart | output | 1 | Cycle-start strobe (S0) |
| opStart | output | 1 | Operand-start strobe (S0, first access only) |
| addrStb | output | 1 | Address strobe |
| dataStb | output | 1 | Data strobe |
| bufEn | output | 1 | Data-buffer enable |
| busAck | input | 2 | Asynchronous size acknowledge from the device |
| busData | input | 32 | Read data bus |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Captured read word |

## Verification
A phase register that holds a wrong value shows up at the strobes in the same cycle, because every strobe is decoded from that register. The per-cycle comparison therefore catches it within one clock. A wrong acknowledge decision, or a wrong synchronizer depth, changes the length of the transfer. That appears as done rising early or late, and it is caught at the first cycle where bufEn or done differs from the model. Capturing data at the wrong edge shows as rdData differing from the lane pattern on the done cycle, because the bench corrupts the bus during S5.

// File: rtl/busrd_pkg.sv
package busrd_pkg;

  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_S0   = 4'd1,
    PH_S1   = 4'd2,
    PH_S2   = 4'd3,
    PH_W1   = 4'd4,
    PH_W2   = 4'd5,
    PH_S3   = 4'd6,
    PH_S4   = 4'd7,
    PH_S5   = 4'd8
  } phase_t;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic capture;    // take the request into the holding registers
    logic startPh;    // S0: cycle start, and operand start when flagged
    logic strobePh;   // S1..S5: address and data strobes
    logic bufPh;      // S2..S5: data buffers open
    logic latchData;  // S4: capture the bus at the closing edge
    logic finish;     // S5: completion next cycle
  } strobes_t;

endpackage

// File: rtl/busrd_sync.sv
module busrd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic             anySeen
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign anySeen = |stageQ[LAST];
endmodule

// File: rtl/busrd_ctrl.sv
module busrd_ctrl
  import busrd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     ackSeen,
  output strobes_t stb,
  output logic     reqReady
);
  phase_t phaseQ, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseNext;
  end

  always_comb begin
    phaseNext = phaseQ;
    unique case (phaseQ)
      PH_IDLE: if (reqValid) phaseNext = PH_S0;
      PH_S0:   phaseNext = PH_S1;
      PH_S1:   phaseNext = PH_S2;
      PH_S2:   phaseNext = ackSeen ? PH_S3 : PH_W1;
      PH_W1:   phaseNext = PH_W2;
      PH_W2:   phaseNext = ackSeen ? PH_S3 : PH_W1;
      PH_S3:   phaseNext = PH_S4;
      PH_S4:   phaseNext = PH_S5;
      PH_S5:   phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    stb           = '0;
    stb.capture   = (phaseQ == PH_IDLE) && reqValid;
    stb.startPh   = (phaseQ == PH_S0);
    stb.strobePh  = (phaseQ != PH_IDLE) && (phaseQ != PH_S0);
    stb.bufPh     = stb.strobePh && (phaseQ != PH_S1);
    stb.latchData = (phaseQ == PH_S4);
    stb.finish    = (phaseQ == PH_S5);
  end

  assign reqReady = (phaseQ == PH_IDLE);
endmodule

// File: rtl/busrd_dpath.sv
module busrd_dpath
  import busrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqFirst,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [SIZE_W-1:0] busSize,
  output logic              busRdWr,
  output logic              cycStart,
  output logic              opStart,
  output logic              addrStb,
  output logic              dataStb,
  output logic              bufEn,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [FC_W-1:0]   fcQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              firstQ;
  logic [DATA_W-1:0] dataQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      fcQ    <= '0;
      sizeQ  <= '0;
      firstQ <= 1'b0;
    end else if (stb.capture) begin
      addrQ  <= reqAddr;
      fcQ    <= reqFc;
      sizeQ  <= reqSize;
      firstQ <= reqFirst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (stb.latchData) dataQ <= busData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= stb.finish;
  end

  assign busAddr  = addrQ;
  assign busFc    = fcQ;
  assign busSize  = sizeQ;
  assign busRdWr  = 1'b1;
  assign cycStart = stb.startPh;
  assign opStart  = stb.startPh & firstQ;
  assign addrStb  = stb.strobePh;
  assign dataStb  = stb.strobePh;
  assign bufEn    = stb.bufPh;
  assign done     = doneQ;
  assign rdData   = dataQ;
endmodule

// File: rtl/busRdMaster.sv
module busRdMaster
  import busrd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FC_W        = 3,
  parameter int SIZE_W      = 2,
  parameter int ACK_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqFirst,
  output logic              reqReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [SIZE_W-1:0] busSize,
  output logic              busRdWr,
  output logic              cycStart,
  output logic              opStart,
  output logic              addrStb,
  output logic              dataStb,
  output logic              bufEn,
  input  logic [ACK_W-1:0]  busAck,
  input  logic [DATA_W-1:0] busData,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  strobes_t stb;
  logic     ackSeen;

  busrd_sync #(.WIDTH(ACK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(busAck), .anySeen(ackSeen)
  );

  busrd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ackSeen(ackSeen),
    .stb(stb), .reqReady(reqReady)
  );

  busrd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W), .SIZE_W(SIZE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqFc(reqFc), .reqSize(reqSize), .reqFirst(reqFirst),
    .busData(busData),
    .busAddr(busAddr), .busFc(busFc), .busSize(busSize), .busRdWr(busRdWr),
    .cycStart(cycStart), .opStart(opStart), .addrStb(addrStb), .dataStb(dataStb),
    .bufEn(bufEn), .done(done), .rdData(rdData)
  );
endmodule

// File: rtl/busRdMaster_chk.sv
module busRdMaster_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              cycStart,
  input logic              opStart,
  input logic              addrStb,
  input logic              dataStb,
  input logic              bufEn,
  input logic              done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!addrStb && !cycStart && !bufEn)); // R9

  AST_OPSTART_IN_S0: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> cycStart); // R3

  AST_S1_FOLLOWS_S0: assert property (@(posedge clk) disable iff (!rstN)
    cycStart |=> (!cycStart && addrStb && dataStb && !bufEn)); // R4

  AST_BUF_INSIDE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    bufEn |-> (addrStb && dataStb)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_AFTER_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrStb) |-> done); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (addrStb && $past(addrStb)) |-> $stable(busAddr)); // R10
endmodule

bind busRdMaster busRdMaster_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busAddr(busAddr),
  .cycStart(cycStart), .opStart(opStart), .addrStb(addrStb), .dataStb(dataStb),
  .bufEn(bufEn), .done(done)
);

// File: tb/busRdMaster_tb.sv
module busRdMaster_tb;
  localparam int P_IDLE = 0, P_S0 = 1, P_S1 = 2, P_S2 = 3, P_W1 = 4,
                 P_W2 = 5, P_S3 = 6, P_S4 = 7, P_S5 = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqFc = '0;
  logic [1:0]  reqSize = '0;
  logic        reqFirst = 1'b0;
  logic [1:0]  busAck = '0;
  logic [31:0] busData = '0;
  logic        reqReady, busRdWr, cycStart, opStart, addrStb, dataStb, bufEn, done;
  logic [31:0] busAddr, rdData;
  logic [2:0]  busFc;
  logic [1:0]  busSize;

  int errs = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  busRdMaster u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqFc(reqFc),
    .reqSize(reqSize), .reqFirst(reqFirst), .reqReady(reqReady), .busAddr(busAddr),
    .busFc(busFc), .busSize(busSize), .busRdWr(busRdWr), .cycStart(cycStart),
    .opStart(opStart), .addrStb(addrStb), .dataStb(dataStb), .bufEn(bufEn),
    .busAck(busAck), .busData(busData), .done(done), .rdData(rdData)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] laneWord(input logic [1:0] a, input logic [1:0] sz);
    int n;
    logic [31:0] w;
    n = (sz == 2'b00) ? 4 : int'(sz);
    w = '0;
    for (int i = 0; i < 4; i++)
      if (i >= int'(a) && i < int'(a) + n)
        w[31 - 8*i -: 8] = 8'(8'h11 * (i + 1)) ^ {6'h15, a};
    return w;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  int          mPh = P_IDLE;
  logic [31:0] eAddr = '0, eData = '0;
  logic [2:0]  eFc = '0;
  logic [1:0]  eSize = '0;
  logic        eFirst = 1'b0, eDone = 1'b0;
  bit          ackHist[$];

  always @(posedge clk) begin
    bit seen;
    if (!rstN) begin
      mPh = P_IDLE; eDone = 1'b0; eData = '0;
      ackHist = {1'b0, 1'b0};
    end else begin
      seen = ackHist[$-1];
      ackHist.push_back(|busAck);
      if (ackHist.size() > 4) void'(ackHist.pop_front());
      eDone = (mPh == P_S5);
      case (mPh)
        P_IDLE: if (reqValid) begin
          mPh = P_S0; eAddr = reqAddr; eFc = reqFc; eSize = reqSize; eFirst = reqFirst;
        end
        P_S0: mPh = P_S1;
        P_S1: mPh = P_S2;
        P_S2: mPh = seen ? P_S3 : P_W1;
        P_W1: mPh = P_W2;
        P_W2: mPh = seen ? P_S3 : P_W1;
        P_S3: mPh = P_S4;
        P_S4: begin eData = busData; mPh = P_S5; end
        default: mPh = P_IDLE;
      endcase
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2", "cycStart", cycStart, 32'(mPh == P_S0));
      chk("R3", "opStart", opStart, 32'(mPh == P_S0 && eFirst));
      chk("R4", "addrStb", addrStb, 32'(mPh >= P_S1));
      chk("R4", "dataStb", dataStb, 32'(mPh >= P_S1));
      chk("R5", "bufEn", bufEn, 32'(mPh >= P_S2));
      chk("R9", "reqReady", reqReady, 32'(mPh == P_IDLE));
      chk("R8", "done", done, 32'(eDone));
      chk("R2", "busRdWr", busRdWr, 32'd1);
      if (eDone) chk("R8", "rdData at done", rdData, eData);
      if (mPh != P_IDLE) begin
        chk("R10", "busAddr", busAddr, eAddr);
        chk("R10", "busFc", 32'(busFc), 32'(eFc));
        chk("R10", "busSize", 32'(busSize), 32'(eSize));
      end
    end
  end

  // Responding device: acknowledges slvK cycles after S0
  bit          slvOn = 1'b0;
  int          slvK = 0, slvCnt = -1;
  logic [1:0]  slvCode = 2'b11;
  logic [31:0] slvData = '0;

  always @(negedge clk) begin
    if (slvOn) begin
      if (cycStart) slvCnt = 0;
      else if (slvCnt >= 0) slvCnt++;
      if (slvCnt == slvK) begin busAck = slvCode; busData = slvData; end
      if (mPh == P_S5) begin busAck = 2'b00; busData = 32'hDEAD_BEEF; slvCnt = -1; end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic runXfer(input logic [31:0] a, input logic [2:0] f, input logic [1:0] sz,
                         input logic first, input int k, input logic [1:0] code,
                         input bit busyPoke);
    int n;
    int w;
    logic [31:0] lanes;
    lanes = laneWord(a[1:0], sz);
    slvK = k; slvCode = code; slvData = lanes;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqFc = f; reqSize = sz; reqFirst = first;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", "S0 cycStart", cycStart, 32'd1);
    chk("R2", "S0 busAddr", busAddr, a);
    chk("R2", "S0 bufEn", bufEn, 32'd0);
    chk("R3", "S0 opStart", opStart, 32'(first));
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R4", "S1 strobes", {addrStb, dataStb, bufEn, cycStart}, 32'b1100);
      if (busyPoke && n == 2) begin reqValid = 1'b1; reqAddr = ~a; end
      if (n == 4) reqValid = 1'b0;
    end
    w = (k + 1) / 2;
    if (k == 0) chk("R6", "cycles S0 to done", n, 6);
    else        chk("R7", "cycles S0 to done", n, 32'(6 + 2 * w));
    chk("R8", "rdData lanes", rdData, lanes);
    chk("R9", "ready after done", reqReady, 32'd1);
    chk("R9", "strobes after done", {addrStb, dataStb, bufEn}, 32'd0);
    if (busyPoke)
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R9", "no cycle from busy request", cycStart, 32'd0);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset strobes", {cycStart, opStart, addrStb, dataStb, bufEn, done}, 32'd0);
    chk("R1", "reset reqReady", reqReady, 32'd1);

    // Acknowledge while idle has no effect (R9)
    busAck = 2'b11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9", "idle ack cycStart", cycStart, 32'd0);
      chk("R9", "idle ack done", done, 32'd0);
    end
    busAck = 2'b00;
    repeat (4) @(negedge clk);

    slvOn = 1'b1;
    runXfer(32'h1000_0000, 3'd5, 2'b00, 1'b1, 0, 2'b11, 1'b0);  // R6 long, no wait
    runXfer(32'h2000_0013, 3'd1, 2'b01, 1'b0, 2, 2'b01, 1'b0);  // R7 byte, one pair
    runXfer(32'h3000_0042, 3'd2, 2'b10, 1'b1, 6, 2'b10, 1'b1);  // R7 word, three pairs, busy poke
    runXfer(32'h4000_0085, 3'd6, 2'b11, 1'b0, 1, 2'b10, 1'b0);  // R7 odd delay, mid-pair ack
    runXfer(32'h5000_00F0, 3'd7, 2'b11, 1'b1, 0, 2'b01, 1'b1);  // R6 three bytes, busy poke
    runXfer(32'h6000_0001, 3'd0, 2'b00, 1'b0, 3, 2'b11, 1'b0);  // R7 odd delay, two pairs
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule